// File: doc/BRIEF.md
# First/Next Error Logging Unit

This block keeps a record of memory-path error events for later inspection by software. Decoded, single-cycle error strobes arrive from three places: the system bus, memory card A and memory card B. Each source can report a single-bit (corrected) error or a double-bit (uncorrectable) error. A per-half parity-error indication arrives from a double-pumped private command bus. Each half of that bus carries a 17-bit command word and its parity bit.

Two status registers hold the error flags. The first-error register holds only the errors of the very first cycle in which anything went wrong. Every later error goes into the next-error register. When the first parity error on the command bus is logged in the first-error register, a capture register freezes the failing command word, its parity bit, and which half of the transfer it came from. Software reads all three registers through a small address/data port. It releases the status flags by writing ones.

Top module: `err_log_unit`

## Requirements
- R1: The status flags sit at fixed positions. Bit 0 is card B single-bit and bit 1 is card B double-bit. Bit 2 is card A single-bit and bit 3 is card A double-bit. Bit 4 is system-bus single-bit and bit 5 is system-bus double-bit. Bit 6 is a command-bus parity error on either half. Address 0 reads the first-error register, address 1 the next-error register, address 2 the capture register, and address 3 reads zero.
- R2: After reset, all three registers read zero.
- R3: An event is logged in the first-error register only when that register is all-zero in the cycle of the event. All events of that cycle are set together, and the register shows them on the following cycle.
- R4: An event that arrives while any first-error bit is set goes to the next-error register, and the first-error register does not gain that bit.
- R5: A write to address 1 clears, for every 1 in the write data, that bit in the next-error register and the same bit in the first-error register.
- R6: A write to address 0 clears only first-error bits where the data is 1. Zero data bits, and any write to address 2 or 3, change no register.
- R7: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: The capture register loads only in a cycle where a parity error is logged into an empty first-error register. Otherwise it holds its value.
- R9: The capture word holds the 17-bit command in bits 16:0, the parity bit seen in bit 17, and a first-half flag in bit 18. Bits 31:19 read zero. Bit 18 is 0 when the fields come from the second half.
- R10: If both halves of one transfer show a parity error, the first-half command and parity are captured and bit 18 is 1.
- R11: Status bits 31:7 always read zero, even after writes of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sb_sec | input | 1 | System-bus single-bit error strobe |
| sb_ded | input | 1 | System-bus double-bit error strobe |
| ca_sec | input | 1 | Card A single-bit error strobe |
| ca_ded | input | 1 | Card A double-bit error strobe |
| cb_sec | input | 1 | Card B single-bit error strobe |
| cb_ded | input | 1 | Card B double-bit error strobe |
| cmd_a | input | 17 | Command word, first half of transfer |
| par_a | input | 1 | Parity bit, first half |
| perr_a | input | 1 | Parity error detected on first half |
| cmd_b | input | 17 | Command word, second half of transfer |
| par_b | input | 1 | Parity bit, second half |
| perr_b | input | 1 | Parity error detected on second half |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data (ones clear flags) |
| reg_rdata | output | 32 | Read data for reg_addr |

## Verification
The assertions assume that every strobe is a clean one-cycle pulse, sampled on the clock edge. They also assume that the command words are valid in any cycle where a half reports a parity error. The clearing-write checks further assume that a write does not race with an event on the same bit, because the set-wins rule covers that case separately. The bench drives every input at the falling edge, holds it across exactly one rising edge and then drops it. Random error strobes are kept sparse enough that both the empty and the occupied first-error state occur often. Writes to all four addresses, with random and all-ones masks, are mixed in among them.

// File: rtl/err_log_pkg.sv
package err_log_pkg;
    localparam int STAT_W = 32;
    localparam int FLAG_N = 7;
    localparam int CMD_W  = 17;

    localparam int F_CB_SEC = 0;
    localparam int F_CB_DED = 1;
    localparam int F_CA_SEC = 2;
    localparam int F_CA_DED = 3;
    localparam int F_SB_SEC = 4;
    localparam int F_SB_DED = 5;
    localparam int F_PERR   = 6;

    localparam logic [1:0] A_FIRST = 2'd0;
    localparam logic [1:0] A_NEXT  = 2'd1;
    localparam logic [1:0] A_CAP   = 2'd2;

    typedef struct packed {
        logic [FLAG_N-1:0] first;
        logic [FLAG_N-1:0] nxt;
    } stat_s;

    typedef struct packed {
        logic             h0;
        logic             par;
        logic [CMD_W-1:0] cmd;
    } cap_s;
endpackage

// File: rtl/err_log_status.sv
module err_log_status
    import err_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] ev,
    input  logic [FLAG_N-1:0] clr_first,
    input  logic [FLAG_N-1:0] clr_next,
    output logic [FLAG_N-1:0] first_q,
    output logic [FLAG_N-1:0] next_q,
    output logic              first_empty
);
    stat_s st_d, st_q;

    assign first_empty = (st_q.first == '0);

    always_comb begin
        st_d.first = st_q.first & ~clr_first;
        st_d.nxt   = st_q.nxt & ~clr_next;
        if (first_empty) begin
            st_d.first = st_d.first | ev;
        end else begin
            st_d.nxt = st_d.nxt | ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign first_q = st_q.first;
    assign next_q  = st_q.nxt;

    // R3
    first_only_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q != '0) |=> ((first_q & ~$past(first_q)) == '0));

    // R4
    later_to_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((first_q != '0) && (ev != '0)) |=> ((next_q & $past(ev)) == $past(ev)));
endmodule

// File: rtl/err_log_capture.sv
module err_log_capture
    import err_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CMD_W-1:0] cmd_a,
    input  logic             par_a,
    input  logic             perr_a,
    input  logic [CMD_W-1:0] cmd_b,
    input  logic             par_b,
    output logic [STAT_W-1:0] cap_word
);
    localparam int PAD_W = STAT_W - CMD_W - 2;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            if (perr_a) begin
                cap_d.h0  = 1'b1;
                cap_d.par = par_a;
                cap_d.cmd = cmd_a;
            end else begin
                cap_d.h0  = 1'b0;
                cap_d.par = par_b;
                cap_d.cmd = cmd_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap_word = {{PAD_W{1'b0}}, cap_q};

    // R8
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cap_word));

    // R10
    cap_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && perr_a) |=> (cap_word[CMD_W+1] && (cap_word[CMD_W-1:0] == $past(cmd_a))));
endmodule

// File: rtl/err_log_unit.sv
module err_log_unit
    import err_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_sec,
    input  logic              sb_ded,
    input  logic              ca_sec,
    input  logic              ca_ded,
    input  logic              cb_sec,
    input  logic              cb_ded,
    input  logic [CMD_W-1:0]  cmd_a,
    input  logic              par_a,
    input  logic              perr_a,
    input  logic [CMD_W-1:0]  cmd_b,
    input  logic              par_b,
    input  logic              perr_b,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata
);
    localparam int UP_W = STAT_W - FLAG_N;

    logic [FLAG_N-1:0] ev;
    logic [FLAG_N-1:0] clr_first, clr_next;
    logic [FLAG_N-1:0] first_q, next_q;
    logic              first_empty;
    logic [STAT_W-1:0] cap_word;

    always_comb begin
        ev           = '0;
        ev[F_CB_SEC] = cb_sec;
        ev[F_CB_DED] = cb_ded;
        ev[F_CA_SEC] = ca_sec;
        ev[F_CA_DED] = ca_ded;
        ev[F_SB_SEC] = sb_sec;
        ev[F_SB_DED] = sb_ded;
        ev[F_PERR]   = perr_a | perr_b;
    end

    always_comb begin
        clr_first = '0;
        clr_next  = '0;
        if (reg_wr && (reg_addr == A_FIRST || reg_addr == A_NEXT))
            clr_first = reg_wdata[FLAG_N-1:0];
        if (reg_wr && reg_addr == A_NEXT)
            clr_next = reg_wdata[FLAG_N-1:0];
    end

    err_log_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .clr_first   (clr_first),
        .clr_next    (clr_next),
        .first_q     (first_q),
        .next_q      (next_q),
        .first_empty (first_empty)
    );

    err_log_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (first_empty & ev[F_PERR]),
        .cmd_a    (cmd_a),
        .par_a    (par_a),
        .perr_a   (perr_a),
        .cmd_b    (cmd_b),
        .par_b    (par_b),
        .cap_word (cap_word)
    );

    always_comb begin
        case (reg_addr)
            A_FIRST: reg_rdata = {{UP_W{1'b0}}, first_q};
            A_NEXT:  reg_rdata = {{UP_W{1'b0}}, next_q};
            A_CAP:   reg_rdata = cap_word;
            default: reg_rdata = '0;
        endcase
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> (((first_q | next_q) & $past(ev)) == $past(ev)));

    // R5
    next_clear_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_NEXT && ev == '0)
        |=> (((first_q | next_q) & $past(reg_wdata[FLAG_N-1:0])) == '0));
endmodule

// File: tb/err_log_unit_tb.sv
module err_log_unit_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sb_sec = 0, sb_ded = 0, ca_sec = 0, ca_ded = 0, cb_sec = 0, cb_ded = 0;
    logic [16:0] cmd_a = '0, cmd_b = '0;
    logic par_a = 0, perr_a = 0, par_b = 0, perr_b = 0;
    logic reg_wr = 0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0, n_fail = 0;
    logic [6:0] mf = '0, mn = '0;
    logic [31:0] mc = '0;

    always #2.5 clk = ~clk;

    err_log_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .sb_sec(sb_sec), .sb_ded(sb_ded), .ca_sec(ca_sec), .ca_ded(ca_ded),
        .cb_sec(cb_sec), .cb_ded(cb_ded),
        .cmd_a(cmd_a), .par_a(par_a), .perr_a(perr_a),
        .cmd_b(cmd_b), .par_b(par_b), .perr_b(perr_b),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.1;
        v = reg_rdata;
    endtask

    // Reference update, written from R3..R10
    function automatic logic [31:0] cap_of(input logic ha, input logic [16:0] c, input logic p);
        return {13'b0, ha, p, c};
    endfunction

    task automatic model_step();
        logic [6:0] ev, cf, cn;
        logic empty;
        ev = {perr_a | perr_b, sb_ded, sb_sec, ca_ded, ca_sec, cb_ded, cb_sec};
        empty = (mf == '0);
        cf = (reg_wr && reg_addr <= 2'd1) ? reg_wdata[6:0] : 7'd0;
        cn = (reg_wr && reg_addr == 2'd1) ? reg_wdata[6:0] : 7'd0;
        if (empty && ev[6])
            mc = perr_a ? cap_of(1'b1, cmd_a, par_a) : cap_of(1'b0, cmd_b, par_b);
        mf = (mf & ~cf) | (empty ? ev : 7'd0);
        mn = (mn & ~cn) | (empty ? 7'd0 : ev);
    endtask

    // Inputs are already set (at a falling edge); cross one rising edge, then release.
    task automatic step();
        @(posedge clk);
        model_step();
        #1;
        {sb_sec, sb_ded, ca_sec, ca_ded, cb_sec, cb_ded} = '0;
        perr_a = 0; perr_b = 0; reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic ecc(input logic [5:0] f);
        @(negedge clk);
        {sb_ded, sb_sec, ca_ded, ca_sec, cb_ded, cb_sec} = f;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic check_model(input string tag);
        logic [31:0] v;
        rd(2'd0, v); chk({tag, " R3 first"}, v, {25'b0, mf});
        rd(2'd1, v); chk({tag, " R4 next"}, v, {25'b0, mn});
        rd(2'd2, v); chk({tag, " R8 capture"}, v, mc);
        rd(2'd3, v); chk({tag, " R1 addr3"}, v, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240607));
        #12; rst_n = 1;
        @(negedge clk);
        rd(2'd0, v); chk("R2 first reset", v, 0);
        rd(2'd1, v); chk("R2 next reset", v, 0);
        rd(2'd2, v); chk("R2 capture reset", v, 0);

        ecc(6'b100000); step();
        rd(2'd0, v); chk("R1 sb_ded bit5 / R3", v, 32'h20);
        ecc(6'b000100); step();
        rd(2'd1, v); chk("R4 ca_sec to next", v, 32'h04);
        rd(2'd0, v); chk("R4 first unchanged", v, 32'h20);
        @(negedge clk); wr(2'd1, 32'h20); step();
        rd(2'd0, v); chk("R5 first cleared via next", v, 0);
        rd(2'd1, v); chk("R5 next keeps bit2", v, 32'h04);
        ecc(6'b000011); step();
        rd(2'd0, v); chk("R3 simultaneous card B", v, 32'h03);
        @(negedge clk); wr(2'd0, 32'h01); step();
        rd(2'd0, v); chk("R6 first clear bit0", v, 32'h02);
        rd(2'd1, v); chk("R6 next untouched", v, 32'h04);
        @(negedge clk); wr(2'd0, 32'h0); step();
        rd(2'd0, v); chk("R6 zero write no effect", v, 32'h02);
        @(negedge clk); wr(2'd3, 32'hFFFF_FFFF); step();
        rd(2'd0, v); chk("R6 addr3 write ignored first", v, 32'h02);
        rd(2'd1, v); chk("R6 addr3 write ignored next", v, 32'h04);
        ecc(6'b010000); wr(2'd1, 32'h10); step();
        rd(2'd1, v); chk("R7 set wins", v, 32'h14);
        @(negedge clk); wr(2'd1, 32'hFFFF_FFFF); step();
        rd(2'd0, v); chk("R11 first upper zero", v, 0);
        rd(2'd1, v); chk("R11 next upper zero", v, 0);

        @(negedge clk);
        cmd_a = 17'h1ABCD; par_a = 1; perr_a = 1;
        cmd_b = 17'h05555; par_b = 0; perr_b = 1;
        step();
        rd(2'd2, v); chk("R10 both halves first half", v, 32'h0007ABCD);
        rd(2'd0, v); chk("R1 parity bit6", v, 32'h40);
        @(negedge clk); cmd_b = 17'h00F0F; par_b = 1; perr_b = 1; step();
        rd(2'd2, v); chk("R8 capture holds", v, 32'h0007ABCD);
        @(negedge clk); wr(2'd1, 32'h7F); step();
        @(negedge clk); cmd_b = 17'h00F0F; par_b = 1; perr_b = 1; step();
        rd(2'd2, v); chk("R9 second half layout", v, 32'h00020F0F);
        @(negedge clk); wr(2'd1, 32'h7F); step();
        rd(2'd2, v); chk("R8 clear keeps capture", v, 32'h00020F0F);

        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            {sb_ded, sb_sec, ca_ded, ca_sec, cb_ded, cb_sec} = '0;
            for (int b = 0; b < 6; b++)
                if ($urandom_range(0, 11) == 0) begin
                    case (b)
                        0: cb_sec = 1; 1: cb_ded = 1; 2: ca_sec = 1;
                        3: ca_ded = 1; 4: sb_sec = 1; default: sb_ded = 1;
                    endcase
                end
            cmd_a = 17'($urandom); par_a = 1'($urandom);
            cmd_b = 17'($urandom); par_b = 1'($urandom);
            perr_a = ($urandom_range(0, 9) == 0);
            perr_b = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 3) == 0) begin
                reg_wr = 1;
                reg_addr = 2'($urandom);
                reg_wdata = ($urandom_range(0, 4) == 0) ? 32'hFFFF_FFFF : $urandom;
            end
            step();
            check_model("rand");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule